// File: doc/BRIEF.md
# Watchdog Timer with Two-Word Service Sequence

This block is a watchdog counter on a plain 32-bit register bus with an address, a write strobe, write data and combinational read data. It runs entirely on the watchdog clock. Software selects a timeout by writing a 5-bit exponent `d` into the configuration word, which gives a period of 2^(d+1) clock cycles. It then enables counting. To keep the system alive, software writes one fixed magic word to a first service register and then a second, different magic word to a second service register. When the count runs out, when a service write is malformed, when software writes the soft-reset register, or when the external user-reset input pulses, the block raises a reset request for one cycle. It also records why in a three-bit cause code.

Two reset inputs are used. The hard (power-on) reset clears everything, including the cause code. The system reset is the one that the block's own request produces in the rest of the chip. It clears the configuration, the counter and the service sequence, but leaves the cause code intact, so software can read it after reboot. Clearing the enable bit does not stop a running count at once. The count stops only when a complete, correct service sequence follows. A new exponent is used only when the counter next restarts.

Top module: `wdog_top`

## Requirements
- R1: Once counting starts (enable write while idle, or a valid service sequence), `rstReq` rises exactly 2^(d+1) clock edges after the starting write edge and stays high for exactly one cycle.
- R2: The configuration word is at byte offset 0x04. Bit 31 is the enable, bits [4:0] are the exponent d, and bits [30:5] always read as zero.
- R3: A write of 0xABCD1234 to offset 0x08, followed by a write of 0x4321DCBA to offset 0x0C, is a valid service sequence. It restarts the count and raises no reset request.
- R4: Any of the following is a bad service write. It raises `rstReq` on the next cycle and sets the cause to 2, and it aborts the sequence:
  - a write to 0x08 with any other value;
  - a write to 0x0C without a valid first word before it;
  - a write to 0x0C with any other value after a valid first word.
- R5: After the enable bit is cleared, the running count continues and can still expire. The count stops only at the next valid service sequence.
- R6: A write to offset 0x00 with bit 0 set raises `rstReq` on the next cycle and sets the cause to 3. With bit 0 clear, the write has no effect.
- R7: A pulse on `userRst` raises `rstReq` on the next cycle and sets the cause to 4.
- R8: On expiry the cause becomes 1 and the enable bit reads back as 0. No further request follows until software enables counting again.
- R9: An exponent written while counting does not change the running period. It takes effect at the next restart.
- R10: Reading offset 0x08 returns the cause in bits [2:0], with all other bits zero. The system reset leaves the cause unchanged, and the hard reset sets it to 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Watchdog clock |
| hardRstN | input | 1 | Power-on reset, active low, clears all state |
| sysRstN | input | 1 | System reset, active low, keeps the cause code |
| userRst | input | 1 | External user reset request pulse |
| busAddr | input | 4 | Byte address of the register access |
| busWe | input | 1 | Write strobe |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Read data for `busAddr` |
| rstReq | output | 1 | One-cycle reset request |

## Verification
The hardest case to reach is the deferred disable: the enable bit reads back as 0 while the counter keeps running. Only the next correct two-word service sequence may stop it. The stimulus reaches this case in two ways:
- It clears the enable just after starting and waits for the expiry to arrive on time anyway.
- It repeats the start and clear, follows with a valid sequence, and then watches a long quiet window.

The deferred exponent is covered the same way: the exponent is changed mid-count and the sequence is timed against both the old period and the new one.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
  localparam int DELAY_W = 5;
  localparam int CNT_W   = 1 << DELAY_W;
  localparam logic [31:0] SVC1_MAGIC = 32'hABCD1234;
  localparam logic [31:0] SVC2_MAGIC = 32'h4321DCBA;

  typedef enum logic [2:0] {
    CAUSE_HARD    = 3'd0,
    CAUSE_TIMEOUT = 3'd1,
    CAUSE_BADSVC  = 3'd2,
    CAUSE_SOFT    = 3'd3,
    CAUSE_USER    = 3'd4
  } cause_e;

  typedef struct packed {
    logic               restart;
    logic               run;
    logic [DELAY_W-1:0] delay;
  } dpCtl_t;
endpackage

// File: rtl/wdog_dp.sv
module wdog_dp
  import wdog_pkg::*;
(
  input  logic   clk,
  input  logic   rstN,
  input  dpCtl_t ctl,
  output logic   expired
);
  logic [CNT_W-1:0]   count;
  logic [CNT_W-1:0]   limit;
  logic [DELAY_W-1:0] activeDelay;

  // limit = 2^(d+1) - 1
  always_comb begin
    limit   = {CNT_W{1'b1}} >> (DELAY_W'(CNT_W - 1) - activeDelay);
    expired = ctl.run && (count == limit);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      count       <= '0;
      activeDelay <= '0;
    end else if (ctl.restart) begin
      count       <= '0;
      activeDelay <= ctl.delay;
    end else if (expired) begin
      count <= '0;
    end else if (ctl.run) begin
      count <= count + 1'b1;
    end
  end

  // R1
  count_in_range_chk: assert property (@(posedge clk) disable iff (!rstN)
    count <= limit);

  // R9
  delay_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !ctl.restart |=> $stable(activeDelay));
endmodule

// File: rtl/wdog_ctrl.sv
module wdog_ctrl
  import wdog_pkg::*;
#(
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              hardRstN,
  input  logic              rstN,
  input  logic              userRst,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWe,
  input  logic [31:0]       busWdata,
  input  logic              expired,
  output dpCtl_t            ctl,
  output logic [31:0]       busRdata,
  output logic              rstReq
);
  localparam logic [ADDR_W-1:0] OFS_SOFT = ADDR_W'(4'h0);
  localparam logic [ADDR_W-1:0] OFS_CFG  = ADDR_W'(4'h4);
  localparam logic [ADDR_W-1:0] OFS_SVC1 = ADDR_W'(4'h8);
  localparam logic [ADDR_W-1:0] OFS_SVC2 = ADDR_W'(4'hC);

  logic               cfgEn, runEn, armed;
  logic [DELAY_W-1:0] cfgDelay;
  cause_e             cause, nextCause;
  logic wrSoft, wrCfg, wrSvc1, wrSvc2;
  logic softEvt, badSvc, svcOk, startEvt, toEvt, anyEvt;

  always_comb begin
    wrSoft   = busWe && (busAddr == OFS_SOFT);
    wrCfg    = busWe && (busAddr == OFS_CFG);
    wrSvc1   = busWe && (busAddr == OFS_SVC1);
    wrSvc2   = busWe && (busAddr == OFS_SVC2);
    softEvt  = wrSoft && busWdata[0];
    svcOk    = wrSvc2 && armed && (busWdata == SVC2_MAGIC);
    badSvc   = (wrSvc1 && (busWdata != SVC1_MAGIC)) || (wrSvc2 && !svcOk);
    startEvt = wrCfg && busWdata[31] && !runEn;
    toEvt    = expired && !svcOk;
    anyEvt   = softEvt || badSvc || userRst || toEvt;

    if (softEvt)      nextCause = CAUSE_SOFT;
    else if (badSvc)  nextCause = CAUSE_BADSVC;
    else if (userRst) nextCause = CAUSE_USER;
    else              nextCause = CAUSE_TIMEOUT;

    ctl.restart = svcOk || startEvt;
    ctl.run     = runEn;
    ctl.delay   = wrCfg ? busWdata[DELAY_W-1:0] : cfgDelay;

    case (busAddr)
      OFS_CFG:  busRdata = {cfgEn, {(31-DELAY_W){1'b0}}, cfgDelay};
      OFS_SVC1: busRdata = {29'd0, cause};
      default:  busRdata = 32'd0;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cfgEn    <= 1'b0;
      cfgDelay <= '0;
      runEn    <= 1'b0;
      armed    <= 1'b0;
      rstReq   <= 1'b0;
    end else begin
      rstReq <= anyEvt;
      if (wrCfg) begin
        cfgEn    <= busWdata[31];
        cfgDelay <= busWdata[DELAY_W-1:0];
      end
      if (wrSvc1)      armed <= (busWdata == SVC1_MAGIC);
      else if (wrSvc2) armed <= 1'b0;
      if (svcOk)         runEn <= cfgEn;
      else if (startEvt) runEn <= 1'b1;
      else if (toEvt)    runEn <= 1'b0;
      if (toEvt) cfgEn <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge hardRstN) begin
    if (!hardRstN)           cause <= CAUSE_HARD;
    else if (rstN && anyEvt) cause <= nextCause;
  end

  // R8
  expiry_req_chk: assert property (@(posedge clk) disable iff (!rstN)
    (expired && !wrSvc2) |=> (rstReq && !runEn && cause == CAUSE_TIMEOUT));

  // R4
  orphan_svc2_chk: assert property (@(posedge clk) disable iff (!rstN)
    (wrSvc2 && !armed) |=> (rstReq && cause == CAUSE_BADSVC));

  // R6
  soft_req_chk: assert property (@(posedge clk) disable iff (!rstN)
    softEvt |=> (rstReq && cause == CAUSE_SOFT));

  // R10
  cause_sticky_chk: assert property (@(posedge clk) disable iff (!hardRstN)
    (cause != $past(cause)) |-> rstReq);
endmodule

// File: rtl/wdog_top.sv
module wdog_top #(
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              hardRstN,
  input  logic              sysRstN,
  input  logic              userRst,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWe,
  input  logic [31:0]       busWdata,
  output logic [31:0]       busRdata,
  output logic              rstReq
);
  wdog_pkg::dpCtl_t ctl;
  logic expired;
  logic rstN;

  assign rstN = hardRstN & sysRstN;

  wdog_ctrl #(.ADDR_W(ADDR_W)) ctrl_i (
    .clk(clk), .hardRstN(hardRstN), .rstN(rstN), .userRst(userRst),
    .busAddr(busAddr), .busWe(busWe), .busWdata(busWdata),
    .expired(expired), .ctl(ctl), .busRdata(busRdata), .rstReq(rstReq)
  );

  wdog_dp dp_i (
    .clk(clk), .rstN(rstN), .ctl(ctl), .expired(expired)
  );
endmodule

// File: tb/wdog_top_tb.sv
module wdog_top_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam logic [31:0] M1 = 32'hABCD1234;
  localparam logic [31:0] M2 = 32'h4321DCBA;

  typedef struct packed {
    logic        we;
    logic [3:0]  addr;
    logic [31:0] data;
    logic [31:0] expRd;
    logic        expRst;
    logic [3:0]  req;
  } vec_t;

  localparam int NVEC = 15;
  localparam vec_t VECS [NVEC] = '{
    '{1'b0, 4'h8, 32'h0,         32'h0,         1'b0, 4'd10}, // R10 cause 0 after hard reset
    '{1'b1, 4'h4, 32'hFFFFFFE7,  32'h0,         1'b0, 4'd2},  // R2 write config
    '{1'b0, 4'h4, 32'h0,         32'h80000007,  1'b0, 4'd2},  // R2 reserved bits zero
    '{1'b1, 4'h8, M1,            32'h0,         1'b0, 4'd3},  // R3 first word
    '{1'b1, 4'hC, M2,            32'h0,         1'b0, 4'd3},  // R3 second word
    '{1'b1, 4'hC, M2,            32'h0,         1'b1, 4'd4},  // R4 second without first
    '{1'b0, 4'h8, 32'h0,         32'h2,         1'b0, 4'd4},  // R4 cause 2
    '{1'b1, 4'h8, 32'h12345678,  32'h0,         1'b1, 4'd4},  // R4 wrong first word
    '{1'b1, 4'h0, 32'h0,         32'h0,         1'b0, 4'd6},  // R6 bit0 clear ignored
    '{1'b0, 4'h8, 32'h0,         32'h2,         1'b0, 4'd6},  // R6 cause unchanged
    '{1'b1, 4'h0, 32'h1,         32'h0,         1'b1, 4'd6},  // R6 soft reset
    '{1'b0, 4'h8, 32'h0,         32'h3,         1'b0, 4'd6},  // R6 cause 3
    '{1'b1, 4'h8, M1,            32'h0,         1'b0, 4'd4},  // R4 valid first word
    '{1'b1, 4'hC, 32'h0,         32'h0,         1'b1, 4'd4},  // R4 wrong second word
    '{1'b0, 4'h8, 32'h0,         32'h2,         1'b0, 4'd4}   // R4 cause 2
  };

  logic clk = 1'b0;
  logic hardRstN = 1'b0, sysRstN = 1'b1, userRst = 1'b0;
  logic [3:0] busAddr = '0;
  logic busWe = 1'b0;
  logic [31:0] busWdata = '0;
  logic [31:0] busRdata;
  logic rstReq;
  int checks = 0, errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  wdog_top dut_i (
    .clk(clk), .hardRstN(hardRstN), .sysRstN(sysRstN), .userRst(userRst),
    .busAddr(busAddr), .busWe(busWe), .busWdata(busWdata),
    .busRdata(busRdata), .rstReq(rstReq)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic write(input logic [3:0] a, input logic [31:0] d);
    busWe = 1'b1; busAddr = a; busWdata = d;
    @(negedge clk);
    busWe = 1'b0;
  endtask

  task automatic readChk(input string req, input logic [3:0] a, input logic [31:0] exp);
    busAddr = a;
    #1;
    check(req, busRdata, exp);
  endtask

  task automatic quiet(input string req, input int n);
    logic seen = 1'b0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (rstReq) seen = 1'b1;
    end
    check(req, {31'd0, seen}, 32'd0);
  endtask

  task automatic kick();
    write(4'h8, M1);
    write(4'hC, M2);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    hardRstN = 1'b1;
    @(negedge clk);
    check("R10 reset rstReq", {31'd0, rstReq}, 32'd0);

    for (int i = 0; i < NVEC; i++) begin
      busWe = VECS[i].we; busAddr = VECS[i].addr; busWdata = VECS[i].data;
      #1;
      if (!VECS[i].we) check($sformatf("R%0d vec %0d read", VECS[i].req, i), busRdata, VECS[i].expRd);
      @(negedge clk);
      busWe = 1'b0;
      check($sformatf("R%0d vec %0d rstReq", VECS[i].req, i), {31'd0, rstReq}, {31'd0, VECS[i].expRst});
    end
    write(4'h4, 32'h0);
    kick();
    quiet("R5 stopped after table", 300);

    // R1 / R8: d=2 gives 8 cycles
    write(4'h4, 32'h80000002);
    repeat (7) @(negedge clk);
    check("R1 before expiry", {31'd0, rstReq}, 32'd0);
    @(negedge clk);
    check("R1 at expiry", {31'd0, rstReq}, 32'd1);
    @(negedge clk);
    check("R1 one-cycle pulse", {31'd0, rstReq}, 32'd0);
    readChk("R8 cause timeout", 4'h8, 32'd1);
    readChk("R8 enable cleared", 4'h4, 32'h00000002);
    quiet("R8 no repeat request", 40);

    // R5: clearing enable does not stop the count
    write(4'h4, 32'h80000003);
    write(4'h4, 32'h00000003);
    repeat (14) @(negedge clk);
    check("R5 before expiry", {31'd0, rstReq}, 32'd0);
    @(negedge clk);
    check("R5 expiry despite clear", {31'd0, rstReq}, 32'd1);
    write(4'h4, 32'h80000003);
    write(4'h4, 32'h00000003);
    kick();
    quiet("R5 stopped by service", 40);

    // R9: delay change applies at next restart
    write(4'h4, 32'h80000004);
    write(4'h4, 32'h80000001);
    repeat (30) @(negedge clk);
    check("R9 old period kept", {31'd0, rstReq}, 32'd0);
    @(negedge clk);
    check("R9 old period expiry", {31'd0, rstReq}, 32'd1);
    write(4'h4, 32'h80000004);
    write(4'h4, 32'h80000001);
    kick();
    repeat (3) @(negedge clk);
    check("R9 new period early", {31'd0, rstReq}, 32'd0);
    @(negedge clk);
    check("R9 new period expiry", {31'd0, rstReq}, 32'd1);

    // R7: user reset
    userRst = 1'b1;
    @(negedge clk);
    userRst = 1'b0;
    check("R7 request", {31'd0, rstReq}, 32'd1);
    readChk("R7 cause user", 4'h8, 32'd4);

    // R10: system reset keeps cause, hard reset clears it
    write(4'h4, 32'h80000005);
    sysRstN = 1'b0;
    repeat (2) @(negedge clk);
    sysRstN = 1'b1;
    readChk("R10 cause kept", 4'h8, 32'd4);
    readChk("R10 config cleared", 4'h4, 32'd0);
    hardRstN = 1'b0;
    @(negedge clk);
    hardRstN = 1'b1;
    @(negedge clk);
    readChk("R10 cause cleared", 4'h8, 32'd0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule